// File: doc/BRIEF.md
# TDM Bit Clock and Frame Sync Generator

This block produces the serial bit clock and the frame sync of a TDM or I2S-style audio link, and it tells the serial datapath where it is inside the frame. Everything runs in one system clock domain. The block has four source tick inputs: one bus tick and three master clock ticks. It selects one of them and counts its ticks to build a bit clock with an even divide ratio between 2 and 512. A frame is a sequence of slots. Slot 0 has its own width, and every other slot shares a second width. The frame sync is active-high or active-low. It can start together with the first bit of the frame, or one bit early, together with the last bit of the previous frame. It stays active for a programmable number of bits.

Either clock can come from a pin instead of being generated. The bit clock direction and the frame sync direction are chosen independently. A received bit clock is synchronised and its edges replace the local divider. A received frame sync restarts the slot and bit counters at its active edge. A received sync that lands anywhere other than the frame boundary raises a one-cycle error pulse. The datapath receives a shift strobe on the edge where outputs change and a sample strobe on the edge where inputs are captured, together with the current slot and bit indices.

Top module: `tdm_clkgen`

## Requirements
- R1: `src_sel` picks the tick that clocks the divider: 0 selects `src_tick[0]` (bus), and 1, 2 and 3 select `src_tick[1]`, `src_tick[2]` and `src_tick[3]` (master clocks).
- R2: With a locally generated bit clock, `bclk_o` toggles once every `div_half_m1+1` selected ticks. The divide ratio is therefore 2×(`div_half_m1`+1), which spans 2 to 512 with the default 8-bit field.
- R3: With `bclk_inv`=0, `bclk_o` falls in the cycle after `shift_stb` and rises in the cycle after `sample_stb`. With `bclk_inv`=1 both edges are swapped. `shift_stb` and `sample_stb` are never high in the same cycle.
- R4: Slot 0 lasts `slot0_len_m1`+1 bits and every later slot lasts `slotn_len_m1`+1 bits. `bit_idx` counts 0 upward inside a slot and `slot_idx` counts 0 upward inside a frame. The frame length is the sum of all slot widths. Indices update in the cycle after `shift_stb`, and the first shift after reset is bit 0 of slot 0.
- R5: The frame holds `slots_m1`+1 slots, except that `slots_m1`=0 still gives a two-slot frame, as a mono stream needs.
- R6: With `fs_early`=0 the generated sync is active for the first `sync_len_m1`+1 bits of each frame, starting at bit 0 of slot 0.
- R7: With `fs_early`=1 the generated sync becomes active on the last bit of the previous frame and stays active for `sync_len_m1`+1 bits in total.
- R8: `fs_inv`=0 makes `fsync_o` active-high. `fs_inv`=1 makes it active-low.
- R9: With `bclk_ext`=1, `bclk_oe` is 0 and `bclk_o` holds the idle level `bclk_inv`. Shift and sample strobes then come from the edges of `bclk_i` after a two-flop synchroniser; a falling edge of `bclk_i` XOR `bclk_inv` means shift.
- R10: With `fs_ext`=1, `fsync_oe` is 0 and `fsync_o` holds its inactive level. An active edge on `fsync_i` (with `fs_inv` applied) restarts the counters, so the bit driven on that bit clock becomes bit 0 of slot 0 when `fs_early`=0.
- R11: After the first received sync, a received sync arriving when the frame is not at its last bit raises `sync_err` for exactly one cycle. The counters still restart at that sync.
- R12: During reset `slot_idx` and `bit_idx` are 0, `sync_err` is 0, `bclk_o` equals `bclk_inv` and `fsync_o` equals `fs_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | One-cycle ticks of bus clock (0) and master clocks (1..3) |
| src_sel | input | 2 | Tick source select |
| div_half_m1 | input | DIV_W | Half-period of bit clock in ticks, minus one |
| bclk_inv | input | 1 | Bit clock polarity |
| bclk_ext | input | 1 | 1: bit clock received on `bclk_i` |
| fs_ext | input | 1 | 1: frame sync received on `fsync_i` |
| fs_early | input | 1 | 1: sync starts one bit early |
| fs_inv | input | 1 | 1: active-low frame sync |
| sync_len_m1 | input | WID_W | Sync width in bits, minus one |
| slot0_len_m1 | input | WID_W | Slot 0 width in bits, minus one |
| slotn_len_m1 | input | WID_W | Width of other slots, minus one |
| slots_m1 | input | SLOT_W | Slots per frame, minus one (0 means two) |
| bclk_i | input | 1 | Bit clock pin input |
| fsync_i | input | 1 | Frame sync pin input |
| bclk_o | output | 1 | Bit clock pin output |
| bclk_oe | output | 1 | Bit clock output enable |
| fsync_o | output | 1 | Frame sync pin output |
| fsync_oe | output | 1 | Frame sync output enable |
| shift_stb | output | 1 | Output-change edge strobe |
| sample_stb | output | 1 | Input-capture edge strobe |
| slot_idx | output | SLOT_W | Current slot |
| bit_idx | output | WID_W | Current bit inside the slot |
| sync_err | output | 1 | Misplaced received sync pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit divider field, 5-bit width and slot fields, and two synchroniser stages. The 8-bit divider field makes the largest ratio of 512 reachable within a short run. The 5-bit slot field lets a four-slot frame with unequal slot widths run next to the mono two-slot case. The two-stage synchroniser gives both pins the same three-cycle latency. That fixed latency lets the bench act as an external master, with its bit clock and sync edges arriving at the counters in a known cycle. It can then place an early sync mid-frame and predict the exact cycle of the error pulse.

// File: rtl/tdmclk_pkg.sv
package tdmclk_pkg;

    typedef enum logic [1:0] {
        SRC_BUS   = 2'd0,
        SRC_MCLK1 = 2'd1,
        SRC_MCLK2 = 2'd2,
        SRC_MCLK3 = 2'd3
    } src_sel_e;

    localparam int NUM_SRC = 4;

endpackage

// File: rtl/tdmclk_divider.sv
module tdmclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hold,
    input  logic [tdmclk_pkg::NUM_SRC-1:0] src_tick,
    input  logic [1:0]                   src_sel,
    input  logic [DIV_W-1:0]             div_half_m1,
    output logic                         lvl,
    output logic                         rise_stb,
    output logic                         fall_stb
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } div_st_t;

    div_st_t s_q, s_d;
    logic    tick;
    logic    wrap;

    always_comb begin
        tick = src_tick[src_sel];
        wrap = tick && (s_q.cnt >= div_half_m1);
        s_d  = s_q;
        if (hold) begin
            s_d.cnt = '0;
            s_d.lvl = 1'b0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.lvl = ~s_q.lvl;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl      = s_q.lvl;
    assign rise_stb = !hold && wrap && !s_q.lvl;
    assign fall_stb = !hold && wrap && s_q.lvl;

    // R9: a received bit clock parks the local divider
    assert_hold_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!s_q.lvl && s_q.cnt == '0));

    // R2: the level only moves on a selected tick or when parked
    assert_toggle_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.lvl) |-> ($past(tick) || $past(hold)));

endmodule

// File: rtl/tdmclk_pin_sync.sv
module tdmclk_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic inv_i,
    output logic lvl_o,
    output logic dly_o
);

    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_i ^ inv_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lvl_o = sh_q[STAGES-1];
    assign dly_o = sh_q[STAGES];

endmodule

// File: rtl/tdmclk_frame_seq.sv
module tdmclk_frame_seq #(
    parameter int WID_W  = 5,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_stb,
    input  logic              fs_ext,
    input  logic              fs_pulse,
    input  logic              early,
    input  logic [WID_W-1:0]  w0_m1,
    input  logic [WID_W-1:0]  wn_m1,
    input  logic [SLOT_W-1:0] ns_m1,
    input  logic [WID_W-1:0]  sw_m1,
    output logic [SLOT_W-1:0] slot_o,
    output logic [WID_W-1:0]  bit_o,
    output logic              fs_act_o,
    output logic              err_o
);

    localparam int POS_W = WID_W + SLOT_W + 1;

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [SLOT_W-1:0] slot;
        logic [WID_W-1:0]  bitc;
        logic              fs;
        logic              fresh;
        logic              locked;
        logic              pend;
        logic              err;
    } seq_st_t;

    seq_st_t           s_q, s_d;
    logic [SLOT_W-1:0] nslots_m1;
    logic [POS_W-1:0]  flen;
    logic [POS_W-1:0]  exp_pos;
    logic [WID_W-1:0]  cur_w_m1;
    logic              restart;

    always_comb begin
        nslots_m1 = (ns_m1 == '0) ? SLOT_W'(1) : ns_m1;
        flen      = POS_W'(w0_m1) + POS_W'(1)
                  + POS_W'(nslots_m1) * (POS_W'(wn_m1) + POS_W'(1));
        exp_pos   = early ? (flen - POS_W'(2)) : (flen - POS_W'(1));
        cur_w_m1  = (s_q.slot == '0) ? w0_m1 : wn_m1;
        restart   = fs_ext && drive_stb && (fs_pulse || s_q.pend);

        s_d      = s_q;
        s_d.err  = 1'b0;
        s_d.pend = fs_ext && !drive_stb && (s_q.pend || fs_pulse);

        if (drive_stb) begin
            s_d.fresh = 1'b0;
            if (restart) begin
                s_d.locked = 1'b1;
                s_d.err    = s_q.locked && (s_q.pos != exp_pos);
                if (early) begin
                    s_d.pos  = flen - POS_W'(1);
                    s_d.slot = nslots_m1;
                    s_d.bitc = wn_m1;
                end else begin
                    s_d.pos  = '0;
                    s_d.slot = '0;
                    s_d.bitc = '0;
                end
            end else if (s_q.fresh) begin
                s_d.pos  = '0;
                s_d.slot = '0;
                s_d.bitc = '0;
            end else if (s_q.bitc == cur_w_m1) begin
                s_d.bitc = '0;
                if (s_q.slot == nslots_m1) begin
                    s_d.slot = '0;
                    s_d.pos  = '0;
                end else begin
                    s_d.slot = s_q.slot + 1'b1;
                    s_d.pos  = s_q.pos + 1'b1;
                end
            end else begin
                s_d.bitc = s_q.bitc + 1'b1;
                s_d.pos  = s_q.pos + 1'b1;
            end
        end

        if (fs_ext) begin
            s_d.fs = 1'b0;
        end else if (drive_stb) begin
            s_d.fs = early ? ((s_d.pos == flen - POS_W'(1)) || (s_d.pos < POS_W'(sw_m1)))
                           : (s_d.pos <= POS_W'(sw_m1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.fresh <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot_o   = s_q.slot;
    assign bit_o    = s_q.bitc;
    assign fs_act_o = s_q.fs;
    assign err_o    = s_q.err;

    // R4: bit index never leaves the width of its slot
    assert_bit_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bitc <= ((s_q.slot == '0) ? w0_m1 : wn_m1));

    // R5: slot index stays inside the frame, which has at least two slots
    assert_slot_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.slot <= nslots_m1);

    // R6: a generated on-time sync starts at the first bit of the frame
    assert_sync_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_ext && !early && $rose(s_q.fs)) |-> (s_q.pos == '0));

    // R11: error pulses only follow a cycle in receive direction
    assert_err_needs_ext_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |-> $past(fs_ext));

endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen #(
    parameter int DIV_W       = 8,
    parameter int WID_W       = 5,
    parameter int SLOT_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_tick,
    input  logic [1:0]        src_sel,
    input  logic [DIV_W-1:0]  div_half_m1,
    input  logic              bclk_inv,
    input  logic              bclk_ext,
    input  logic              fs_ext,
    input  logic              fs_early,
    input  logic              fs_inv,
    input  logic [WID_W-1:0]  sync_len_m1,
    input  logic [WID_W-1:0]  slot0_len_m1,
    input  logic [WID_W-1:0]  slotn_len_m1,
    input  logic [SLOT_W-1:0] slots_m1,
    input  logic              bclk_i,
    input  logic              fsync_i,
    output logic              bclk_o,
    output logic              bclk_oe,
    output logic              fsync_o,
    output logic              fsync_oe,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [WID_W-1:0]  bit_idx,
    output logic              sync_err
);

    logic div_lvl, div_rise, div_fall;
    logic b_lvl, b_dly, f_lvl, f_dly;
    logic fs_act;

    tdmclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (bclk_ext),
        .src_tick    (src_tick),
        .src_sel     (src_sel),
        .div_half_m1 (div_half_m1),
        .lvl         (div_lvl),
        .rise_stb    (div_rise),
        .fall_stb    (div_fall)
    );

    tdmclk_pin_sync #(.STAGES(SYNC_STAGES)) u_bsync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (bclk_i),
        .inv_i (bclk_inv),
        .lvl_o (b_lvl),
        .dly_o (b_dly)
    );

    tdmclk_pin_sync #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (fsync_i),
        .inv_i (fs_inv),
        .lvl_o (f_lvl),
        .dly_o (f_dly)
    );

    assign shift_stb  = bclk_ext ? (b_dly & ~b_lvl) : div_fall;
    assign sample_stb = bclk_ext ? (b_lvl & ~b_dly) : div_rise;

    tdmclk_frame_seq #(.WID_W(WID_W), .SLOT_W(SLOT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_stb (shift_stb),
        .fs_ext    (fs_ext),
        .fs_pulse  (f_lvl & ~f_dly),
        .early     (fs_early),
        .w0_m1     (slot0_len_m1),
        .wn_m1     (slotn_len_m1),
        .ns_m1     (slots_m1),
        .sw_m1     (sync_len_m1),
        .slot_o    (slot_idx),
        .bit_o     (bit_idx),
        .fs_act_o  (fs_act),
        .err_o     (sync_err)
    );

    assign bclk_o   = bclk_ext ? bclk_inv : (div_lvl ^ bclk_inv);
    assign bclk_oe  = ~bclk_ext;
    assign fsync_o  = fs_act ^ fs_inv;
    assign fsync_oe = ~fs_ext;

    // R3: shift and sample edges never coincide
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_stb, sample_stb}));

endmodule

// File: tb/sim_tdm_clkgen.sv
module sim_tdm_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_tick;
    logic [1:0] src_sel = 2'd0;
    logic [7:0] div_half_m1 = 8'd0;
    logic       bclk_inv = 1'b0, bclk_ext = 1'b0, fs_ext = 1'b0;
    logic       fs_early = 1'b0, fs_inv = 1'b0;
    logic [4:0] sync_len_m1 = 5'd0, slot0_len_m1 = 5'd0, slotn_len_m1 = 5'd0;
    logic [4:0] slots_m1 = 5'd0;
    logic       bclk_i = 1'b0, fsync_i = 1'b0;
    logic       bclk_o, bclk_oe, fsync_o, fsync_oe, shift_stb, sample_stb, sync_err;
    logic [4:0] slot_idx;
    logic [4:0] bit_idx;

    int checks = 0;
    int fails  = 0;
    int tcnt   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tdm_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
        .div_half_m1(div_half_m1), .bclk_inv(bclk_inv), .bclk_ext(bclk_ext),
        .fs_ext(fs_ext), .fs_early(fs_early), .fs_inv(fs_inv),
        .sync_len_m1(sync_len_m1), .slot0_len_m1(slot0_len_m1),
        .slotn_len_m1(slotn_len_m1), .slots_m1(slots_m1),
        .bclk_i(bclk_i), .fsync_i(fsync_i), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
        .fsync_o(fsync_o), .fsync_oe(fsync_oe), .shift_stb(shift_stb),
        .sample_stb(sample_stb), .slot_idx(slot_idx), .bit_idx(bit_idx),
        .sync_err(sync_err)
    );

    // tick sources: bus every cycle, master clocks every 2, 3 and 4 cycles
    initial begin
        src_tick = 4'b0001;
        forever begin
            @(negedge clk);
            tcnt = tcnt + 1;
            src_tick = {tcnt % 4 == 0, tcnt % 3 == 0, tcnt % 2 == 0, 1'b1};
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_shift();
        do @(negedge clk); while (!shift_stb);
    endtask

    // divider vectors: {sel, div, expected half period in clk cycles}
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{0, 0,   1},
        '{0, 5,   6},
        '{1, 2,   6},
        '{2, 1,   6},
        '{3, 3,  16},
        '{0, 255, 256}
    };

    task automatic run_frames(input int w0m1, input int wnm1, input int nsm1,
                              input int swm1, input bit early, input bit finv,
                              input int nbits);
        int nsl, flen, pos, es, eb, act;
        slot0_len_m1 = 5'(w0m1); slotn_len_m1 = 5'(wnm1); slots_m1 = 5'(nsm1);
        sync_len_m1 = 5'(swm1); fs_early = early; fs_inv = finv;
        src_sel = 2'd0; div_half_m1 = 8'd0; bclk_ext = 1'b0; fs_ext = 1'b0;
        bclk_inv = 1'b0;
        do_reset();
        nsl  = (nsm1 == 0) ? 2 : nsm1 + 1;
        flen = (w0m1 + 1) + (nsl - 1) * (wnm1 + 1);
        for (int k = 0; k < nbits; k++) begin
            wait_shift();
            @(negedge clk);
            pos = k % flen;
            if (pos <= w0m1) begin
                es = 0; eb = pos;
            end else begin
                es = 1 + (pos - w0m1 - 1) / (wnm1 + 1);
                eb = (pos - w0m1 - 1) % (wnm1 + 1);
            end
            if (early) act = (pos == flen - 1 || pos < swm1) ? 1 : 0;
            else       act = (pos <= swm1) ? 1 : 0;
            check_eq("R4 slot_idx", int'(slot_idx), es);
            check_eq("R4 bit_idx", int'(bit_idx), eb);
            check_eq(early ? "R7 R8 fsync_o" : "R6 R8 fsync_o", int'(fsync_o), act ^ int'(finv));
        end
    endtask

    task automatic pol_check(input bit inv);
        src_sel = 2'd0; div_half_m1 = 8'd1; bclk_inv = inv; bclk_ext = 1'b0;
        fs_ext = 1'b0;
        do_reset();
        wait_shift();
        check_eq("R3 bclk before shift edge", int'(bclk_o), int'(!inv));
        @(negedge clk);
        check_eq("R3 bclk after shift edge", int'(bclk_o), int'(inv));
        do @(negedge clk); while (!sample_stb);
        check_eq("R3 bclk before sample edge", int'(bclk_o), int'(inv));
        @(negedge clk);
        check_eq("R3 bclk after sample edge", int'(bclk_o), int'(!inv));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int nshift, bad_bclk, m, errs, c1, c2, prev;
        bit lock;

        // R12 reset state
        bclk_inv = 1'b1; fs_inv = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R12 slot_idx in reset", int'(slot_idx), 0);
        check_eq("R12 bit_idx in reset", int'(bit_idx), 0);
        check_eq("R12 sync_err in reset", int'(sync_err), 0);
        check_eq("R12 bclk_o in reset", int'(bclk_o), 1);
        check_eq("R12 fsync_o in reset", int'(fsync_o), 1);
        fs_inv = 1'b0; bclk_inv = 1'b0;

        // R1 R2 divider table
        for (int v = 0; v < NVEC; v++) begin
            src_sel = 2'(VEC[v][0]); div_half_m1 = 8'(VEC[v][1]);
            do_reset();
            @(negedge clk);
            prev = int'(bclk_o);
            c1 = -1; c2 = -1;
            for (int c = 0; c < 2000 && c2 < 0; c++) begin
                @(negedge clk);
                if (int'(bclk_o) != prev) begin
                    if (c1 < 0) c1 = c; else c2 = c;
                end
                prev = int'(bclk_o);
            end
            check_eq("R1 R2 bclk half period", c2 - c1, VEC[v][2]);
        end

        // R3 polarity
        pol_check(1'b0);
        pol_check(1'b1);

        // R4 R6: three slots, wide slot 0, on-time word-length sync
        run_frames(7, 3, 2, 7, 1'b0, 1'b0, 32);
        // R5 R7 R8: mono two-slot frame, early one-bit active-low sync
        run_frames(3, 3, 0, 0, 1'b1, 1'b1, 16);
        // R4 R7: four unequal slots, early three-bit sync
        run_frames(1, 2, 3, 2, 1'b1, 1'b0, 22);

        // R9 received bit clock
        bclk_ext = 1'b1; fs_ext = 1'b0; bclk_inv = 1'b0; bclk_i = 1'b0;
        div_half_m1 = 8'd0; src_sel = 2'd0;
        do_reset();
        nshift = 0; bad_bclk = 0;
        for (int c = 0; c < 63; c++) begin
            @(negedge clk);
            if (shift_stb) nshift++;
            if (bclk_o !== 1'b0) bad_bclk++;
            bclk_i = ((c / 3) % 2 == 1);
        end
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (shift_stb) nshift++;
        end
        check_eq("R9 shifts from pin edges", nshift, 10);
        check_eq("R9 bclk_o held idle", bad_bclk, 0);
        check_eq("R9 bclk_oe low", int'(bclk_oe), 0);

        // R10 R11 received bit clock and frame sync, 2 x 4-bit slots
        bclk_ext = 1'b1; fs_ext = 1'b1; fs_early = 1'b0; fs_inv = 1'b0;
        slot0_len_m1 = 5'd3; slotn_len_m1 = 5'd3; slots_m1 = 5'd1;
        bclk_i = 1'b1; fsync_i = 1'b0;
        do_reset();
        repeat (4) @(negedge clk);
        m = 3; lock = 1'b0; errs = 0;
        for (int t = 0; t < 32; t++) begin
            if (t == 16) m = 0;
            bclk_i = 1'b0;
            fsync_i = (m == 0);
            if (m == 0) lock = 1'b1;
            @(negedge clk);
            @(negedge clk);
            bclk_i = 1'b1;
            @(negedge clk);
            if (lock) begin
                check_eq("R10 slot_idx follows received sync", int'(slot_idx), m / 4);
                check_eq("R10 bit_idx follows received sync", int'(bit_idx), m % 4);
            end
            if (sync_err) errs++;
            if (t == 16) check_eq("R11 sync_err on early sync", int'(sync_err), 1);
            @(negedge clk);
            m = (m + 1) % 8;
        end
        check_eq("R11 sync_err pulse count", errs, 1);
        check_eq("R10 fsync_oe low", int'(fsync_oe), 0);
        check_eq("R10 fsync_o idle", int'(fsync_o), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule